// File: doc/BRIEF.md
# I2C Bus Clock Divider

This block derives the bus clock timing of an I2C engine from the system clock. It cascades four stages. A linear counter runs for the high-period count plus one cycles. A power-of-two prescaler follows, then a linear divider by M+1, then a fixed divide-by-ten. When the last stage wraps, the block ends one half of a bus clock period. It then issues a one-cycle enable pulse and flips a phase output. The engine uses the pulse to step its state machine, and it uses the phase to drive the clock line low or high.

Software picks the three settings for a target rate, and that search is outside this block. The block takes the 8-bit high-period count and a 7-bit clock control word, which holds M and N. It copies them into working registers only when a half period ends. A change made in the middle of a phase therefore never shortens or lengthens that phase. Settings outside the supported range are raised to the smallest supported value.

Top module: `i2c_sclgen_div`

## Requirements
- R1: While reset is held and in the cycle after reset, the pulse output is 0 and the phase output is 0. The first half period after reset uses the working defaults: high-period count 0x18, M = 2 and N = 0. That half period is 750 cycles long.
- R2: The pulse output goes high once at the end of every half period. Two consecutive pulses are exactly (T+1)·2^N·(M+1)·10 system cycles apart, where T, M and N are the working settings. The bus clock frequency is therefore f_sys / (2·(T+1)) / 2^N / (M+1) / 10.
- R3: In the clock control input, M sits in bits 6:3 and N sits in bits 2:0. The fixed divide-by-ten stage has no setting.
- R4: The block copies the settings inputs into its working registers only in the clock edge that raises the pulse. The new values govern the half period that begins at that edge. Any values the inputs take in between, including values that change several times, have no effect.
- R5: The phase output inverts at every pulse and holds its value in every other cycle. The two halves of a period under one setting therefore have equal length.
- R6: The pulse lasts exactly one system cycle.
- R7: A high-period count below 5 acts as 5.
- R8: An M value below 2 acts as 2.
- R9: N covers the whole range from 0 to 7. At N = 7 the prescaler divides by 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_hper_i | input | 8 | High-period count T |
| cfg_ctl_i | input | 7 | Clock control word, M in [6:3], N in [2:0] |
| scl_tick_o | output | 1 | One-cycle pulse at each half-period boundary |
| scl_phase_o | output | 1 | Bus clock phase, inverts at every pulse |

## Verification
The assertions check four things in every cycle. The pulse is one cycle wide. The phase flips only together with a pulse. The working settings change only in a pulse cycle. The working settings never fall below their floors. The bench scenarios are needed to show that the cascade gives the exact half-period length for each combination of settings. They also show that the field positions of M and N are right, that the reset defaults hold, and that a setting changed in the middle of a phase first appears one half period later.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

    localparam int HPER_W    = 8;
    localparam int MDIV_W    = 4;
    localparam int NDIV_W    = 3;
    localparam int CTL_W     = MDIV_W + NDIV_W;

    localparam logic [HPER_W-1:0] HPER_MIN = HPER_W'(5);
    localparam logic [MDIV_W-1:0] MDIV_MIN = MDIV_W'(2);
    localparam logic [HPER_W-1:0] HPER_RST = HPER_W'(8'h18);
    localparam logic [MDIV_W-1:0] MDIV_RST = MDIV_W'(2);
    localparam logic [NDIV_W-1:0] NDIV_RST = NDIV_W'(0);

    typedef struct packed {
        logic [HPER_W-1:0] hper;
        logic [MDIV_W-1:0] mdiv;
        logic [NDIV_W-1:0] ndiv;
    } sclgen_cfg_t;

    // Split the control word and raise out-of-range settings to their floor.
    function automatic sclgen_cfg_t unpack_cfg(input logic [HPER_W-1:0] hper,
                                               input logic [CTL_W-1:0]  ctl);
        sclgen_cfg_t c;
        c.hper = (hper < HPER_MIN) ? HPER_MIN : hper;
        c.mdiv = (ctl[CTL_W-1:NDIV_W] < MDIV_MIN) ? MDIV_MIN : ctl[CTL_W-1:NDIV_W];
        c.ndiv = ctl[NDIV_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/sclgen_cfg_shadow.sv
module sclgen_cfg_shadow
    import sclgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [HPER_W-1:0] hper_i,
    input  logic [CTL_W-1:0]  ctl_i,
    output sclgen_cfg_t       cfg_o
);

    typedef struct packed {
        sclgen_cfg_t cfg;
    } shadow_st_t;

    shadow_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.cfg = unpack_cfg(hper_i, ctl_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg.hper <= HPER_RST;
            st_q.cfg.mdiv <= MDIV_RST;
            st_q.cfg.ndiv <= NDIV_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q.cfg;

endmodule

// File: rtl/sclgen_lin_stage.sv
module sclgen_lin_stage #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic [CW-1:0] limit_i,
    output logic          wrap_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } lin_st_t;

    lin_st_t st_d, st_q;
    logic    at_end;

    always_comb begin
        st_d   = st_q;
        at_end = (st_q.cnt >= limit_i);
        wrap_o = step_i && at_end;
        if (step_i) begin
            st_d.cnt = at_end ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sclgen_pow2_stage.sv
module sclgen_pow2_stage #(
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic [SW-1:0] sel_i,
    output logic          wrap_o
);

    localparam int CW = (1 << SW) - 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } p2_st_t;

    p2_st_t        st_d, st_q;
    logic [CW-1:0] mask;

    // Low sel_i bits of the mask are set: the counter wraps after 2^sel_i steps.
    for (genvar gi = 0; gi < CW; gi++) begin : g_mask
        assign mask[gi] = (SW'(gi) < sel_i);
    end

    always_comb begin
        st_d   = st_q;
        wrap_o = step_i && ((st_q.cnt & mask) == mask);
        if (step_i) begin
            st_d.cnt = wrap_o ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/i2c_sclgen_div.sv
module i2c_sclgen_div
    import sclgen_pkg::*;
#(
    parameter int FIXED_DIV = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HPER_W-1:0] cfg_hper_i,
    input  logic [CTL_W-1:0]  cfg_ctl_i,
    output logic              scl_tick_o,
    output logic              scl_phase_o
);

    localparam int FD_W = $clog2(FIXED_DIV);

    typedef struct packed {
        logic tick;
        logic phase;
    } out_st_t;

    out_st_t     st_d, st_q;
    sclgen_cfg_t cfg_cur;
    logic        wrap_hper, wrap_pow2, wrap_mdiv, wrap_fix;

    sclgen_cfg_shadow u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (wrap_fix),
        .hper_i (cfg_hper_i),
        .ctl_i  (cfg_ctl_i),
        .cfg_o  (cfg_cur)
    );

    sclgen_lin_stage #(.CW(HPER_W)) u_hper (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (1'b1),
        .limit_i (cfg_cur.hper),
        .wrap_o  (wrap_hper)
    );

    sclgen_pow2_stage #(.SW(NDIV_W)) u_pow2 (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (wrap_hper),
        .sel_i  (cfg_cur.ndiv),
        .wrap_o (wrap_pow2)
    );

    sclgen_lin_stage #(.CW(MDIV_W)) u_mdiv (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (wrap_pow2),
        .limit_i (cfg_cur.mdiv),
        .wrap_o  (wrap_mdiv)
    );

    sclgen_lin_stage #(.CW(FD_W)) u_fix (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (wrap_mdiv),
        .limit_i (FD_W'(FIXED_DIV - 1)),
        .wrap_o  (wrap_fix)
    );

    always_comb begin
        st_d       = st_q;
        st_d.tick  = wrap_fix;
        st_d.phase = st_q.phase ^ wrap_fix;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_tick_o  = st_q.tick;
    assign scl_phase_o = st_q.phase;

endmodule

// File: rtl/sclgen_div_chk.sv
module sclgen_div_chk
    import sclgen_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        phase,
    input sclgen_cfg_t cfg
);

    assert_tick_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    assert_phase_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (phase != $past(phase)));

    assert_phase_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |-> $stable(phase));

    assert_cfg_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg) |-> tick);

    assert_hper_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.hper >= HPER_MIN);

    assert_mdiv_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.mdiv >= MDIV_MIN);

endmodule

bind i2c_sclgen_div sclgen_div_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (scl_tick_o),
    .phase (scl_phase_o),
    .cfg   (cfg_cur)
);

// File: tb/i2c_sclgen_div_tb_top.sv
module i2c_sclgen_div_tb_top;

    typedef struct {
        int    len;
        string tag;
    } exp_t;

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] hper  = 8'd5;
    logic [6:0] ctl   = 7'd0;
    logic       tick, phase;

    int   total = 0;
    int   bad   = 0;
    int   gap   = 0;
    bit   done  = 0;
    bit   after_tick = 0;
    bit   prev_phase = 0;
    exp_t exp_q[$];
    exp_t cur;

    always #5 clk = ~clk;

    i2c_sclgen_div dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_hper_i  (hper),
        .cfg_ctl_i   (ctl),
        .scl_tick_o  (tick),
        .scl_phase_o (phase)
    );

    task automatic check_eq(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int half_len(int t, int m, int n);
        int tt = (t < 5) ? 5 : t;
        int mm = (m < 2) ? 2 : m;
        return (tt + 1) * (1 << n) * (mm + 1) * 10;
    endfunction

    // R3: M goes to bits 6:3, N to bits 2:0.
    task automatic set_cfg(int t, int m, int n);
        hper = t[7:0];
        ctl  = {m[3:0], n[2:0]};
    endtask

    task automatic wait_ticks(int k);
        repeat (k) begin
            do @(negedge clk); while (!tick);
        end
    endtask

    // Driver: program a setting, queue the expected half periods, wait them out.
    task automatic run_cfg(int t, int m, int n, int reps, int pre_dly, string tag);
        if (pre_dly > 0) begin
            set_cfg(255, 15, 7);          // R4: transient value, never sampled
            repeat (pre_dly) @(negedge clk);
        end
        set_cfg(t, m, n);
        for (int i = 0; i < reps; i++) begin
            exp_t e;
            e.len = half_len(t, m, n);
            e.tag = tag;
            exp_q.push_back(e);
        end
        wait_ticks(reps);
    endtask

    // Monitor: measure the spacing of pulses and compare with the queue.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            gap++;
            if (after_tick) check_eq("R6 pulse width", int'(tick), 0);
            after_tick = tick;
            if (tick) begin
                check_eq("R5 phase inverts at pulse", int'(phase), int'(!prev_phase));
                prev_phase = phase;
                if (exp_q.size() == 0) begin
                    check_eq("R2 pulse without expectation", 1, 0);
                end else begin
                    cur = exp_q.pop_front();
                    check_eq(cur.tag, gap, cur.len);
                end
                gap = 0;
            end
        end
    end

    initial begin
        exp_t e0;
        set_cfg(5, 2, 0);
        e0.len = half_len(8'h18, 2, 0);
        e0.tag = "R1 reset default half period";
        exp_q.push_back(e0);
        repeat (4) @(negedge clk);
        check_eq("R1 pulse low in reset", int'(tick), 0);
        check_eq("R1 phase low in reset", int'(phase), 0);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 pulse low after reset", int'(tick), 0);
        check_eq("R1 phase low after reset", int'(phase), 0);

        run_cfg(5, 2, 0, 3, 0, "R2 T=5 M=2 N=0");
        run_cfg(9, 3, 2, 2, 100, "R4 R3 T=9 M=3 N=2 after mid-phase change");
        run_cfg(4, 1, 1, 2, 0, "R7 R8 clamped T=4 M=1 N=1");
        run_cfg(255, 2, 0, 2, 0, "R2 T=255 M=2 N=0");
        run_cfg(5, 15, 3, 2, 0, "R3 T=5 M=15 N=3");
        run_cfg(5, 2, 7, 1, 0, "R9 T=5 M=2 N=7");
        wait_ticks(1);
        @(negedge clk);
        done = 1;
        check_eq("R2 all expected half periods seen", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule